// File: doc/BRIEF.md
# Code Prefetch Queue

This block sits between a byte-oriented processor core and a slow external code memory. It runs ahead of the execution unit and keeps a four-byte queue topped up. While the core spends several states on a slow instruction, the queue keeps filling. The bytes gathered that way are then handed over without any memory delay. When the queue runs dry, the core sees no valid byte and stalls until the next fetch completes.

Fetch timing is counted in states of two clock cycles each. The memory configuration is applied at the start of every byte fetch and fixes the cost of that byte:

- Page mode costs one state per byte.
- Non-page mode costs two states per byte, plus one state for each configured wait state.

A flush input models a taken branch. It drops everything queued, abandons the fetch in flight and restarts fetching at a new address.

On the memory side the block drives a 16-bit address and a request strobe. The strobe stays high for the whole fetch of one byte, and the read data is taken in the last cycle of that fetch.

Top module: `code_prefetch_queue`

## Requirements
- R1: A state is two clock cycles, and state 0 begins in the first cycle after reset is released. A byte fetch (`mem_req` high) begins only in the first cycle of a state, which is an even cycle counted from reset release, and it ends in the last cycle of a state.
- R2: With `cfg_page`=1, each byte fetch keeps `mem_req` high with a fixed `mem_addr` for exactly 2 clock cycles (one state).
- R3: With `cfg_page`=0, each byte fetch lasts (2+N) states, which is 2*(2+N) clock cycles. N is `cfg_wait` (3 bits), and any value above 4 counts as 4.
- R4: The queue holds at most 4 bytes, and no fetch starts while it cannot take one more byte. `q_full` and `q_empty` are registered, so they change in the cycle after the push or pop that causes them.
- R5: Bytes leave in the order their addresses were fetched. `out_valid` and `out_byte` present the oldest byte in the same cycle. Each stored byte is the `mem_rdata` value seen in the last cycle of its fetch.
- R6: The fetch address rises by one after each completed byte and wraps from 16'hFFFF to 16'h0000. The address is held constant throughout a fetch.
- R7: A cycle with `flush`=1 empties the queue, so `out_valid` is 0 in the next cycle. It also discards the fetch in progress, whose byte never appears. It loads `flush_addr`, and the next fetch starts at the following state boundary, one or two cycles later.
- R8: The memory configuration is sampled only when a fetch starts. Changing it mid-fetch leaves the length of that fetch unchanged and affects only the next one.
- R9: A pop and a completing fetch in the same cycle are both honoured. A pop while the queue is empty is ignored and removes no later byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page | input | 1 | 1 = page mode, 0 = non-page mode |
| cfg_wait | input | 3 | Wait states for non-page mode (values above 4 act as 4) |
| flush | input | 1 | Discard the queue and redirect fetching |
| flush_addr | input | 16 | New fetch address loaded on flush |
| mem_req | output | 1 | High for every cycle of a byte fetch |
| mem_addr | output | 16 | Address of the byte being fetched |
| mem_rdata | input | 8 | Code byte returned by external memory |
| out_valid | output | 1 | The queue head holds a byte |
| out_byte | output | 8 | Oldest queued byte |
| out_pop | input | 1 | Consume the head byte |
| q_full | output | 1 | Registered: queue holds 4 bytes |
| q_empty | output | 1 | Registered: queue holds no byte |

## Verification
Fetch length is measured on the memory strobe in five configurations:

- page mode;
- zero, two and four wait states;
- an out-of-range wait count.

These separate the per-state cost from the fixed two-state base and show the clamp. Filling without pops shows that the queue stops at four bytes and fetching pauses, and the later pops confirm ordering and resumption. Streaming with a pop on nearly every cycle shows that same-cycle pop and fill lose no byte, and a start just below 16'hFFFF shows the address wrap. A flush in the middle of a slow fetch, a configuration change in the middle of a fetch, and pops on an empty queue each show that only the intended state changes.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned MAX_WAIT = 4;
  localparam int unsigned WS_W     = 3;

  // States needed for one code byte under the given configuration
  function automatic int unsigned byte_states(input logic page, input logic [WS_W-1:0] ws);
    int unsigned n;
    n = (32'(ws) > MAX_WAIT) ? MAX_WAIT : 32'(ws);
    return page ? 32'd1 : (32'd2 + n);
  endfunction

  // Clock cycles for one code byte: each state spans two cycles
  function automatic int unsigned byte_cycles(input logic page, input logic [WS_W-1:0] ws);
    return 32'd2 * byte_states(page, ws);
  endfunction
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full_q,
  output logic          empty_q,
  output logic          room
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          push_ok, pop_ok;

  assign push_ok = push && !clr;
  assign pop_ok  = pop && !empty_q && !clr;
  assign cnt_nx  = clr ? '0 : (cnt_q + CW'(push_ok) - CW'(pop_ok));
  assign room    = (cnt_nx < CW'(DEPTH));
  assign dout    = slots[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nx;
      full_q  <= (cnt_nx == CW'(DEPTH));
      empty_q <= (cnt_nx == '0);
      if (clr) begin
        rd_q <= '0;
        wr_q <= '0;
      end else begin
        if (push_ok) wr_q <= wr_q + 1'b1;
        if (pop_ok)  rd_q <= rd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_q] <= din;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full_q);
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_page,
  input  logic [pfq_pkg::WS_W-1:0] cfg_wait,
  input  logic                     flush,
  input  logic [ADDR_W-1:0]        flush_addr,
  input  logic                     room,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     push
);
  logic              phase_q;   // 1 in the second cycle of a state
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  load_val;
  logic              byte_done, launch;

  assign load_val  = CNT_W'(pfq_pkg::byte_cycles(cfg_page, cfg_wait) - 32'd1);
  assign byte_done = busy_q && (cnt_q == '0);
  // Start the next fetch so that it begins on the coming state boundary
  assign launch    = phase_q && room && (flush || !busy_q || byte_done);
  assign push      = byte_done && !flush;
  assign mem_req   = busy_q;
  assign mem_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (launch)                  busy_q <= 1'b1;
      else if (byte_done || flush) busy_q <= 1'b0;
      if (launch)      cnt_q <= load_val;
      else if (busy_q) cnt_q <= cnt_q - 1'b1;
      if (flush)          addr_q <= flush_addr;
      else if (byte_done) addr_q <= addr_q + 1'b1;
    end
  end

  p_start_on_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !phase_q);
  p_end_on_state_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> phase_q);
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !byte_done && !flush) |=> $stable(addr_q));
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !flush) |=> (addr_q == $past(addr_q) + 1'b1));
  p_count_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !byte_done && !flush) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_page,
  input  logic [pfq_pkg::WS_W-1:0] cfg_wait,
  input  logic                     flush,
  input  logic [ADDR_W-1:0]        flush_addr,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic [7:0]               mem_rdata,
  output logic                     out_valid,
  output logic [7:0]               out_byte,
  input  logic                     out_pop,
  output logic                     q_full,
  output logic                     q_empty
);
  localparam int MAX_CYC = 2 * (2 + int'(pfq_pkg::MAX_WAIT));
  localparam int CNT_W   = $clog2(MAX_CYC);

  logic fill_push;
  logic fill_room;

  pfq_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk, .rst_n, .cfg_page, .cfg_wait, .flush, .flush_addr,
    .room(fill_room), .mem_req, .mem_addr, .push(fill_push)
  );

  pfq_fifo #(.DEPTH(DEPTH), .DW(8)) u_queue (
    .clk, .rst_n, .clr(flush), .push(fill_push), .din(mem_rdata),
    .pop(out_pop), .dout(out_byte), .full_q(q_full), .empty_q(q_empty),
    .room(fill_room)
  );

  assign out_valid = !q_empty;

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  p_no_fetch_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !out_pop && !flush && !mem_req) |=> !mem_req);
endmodule

// File: tb/code_prefetch_queue_tb.sv
module code_prefetch_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page = 1'b1;
  logic [2:0]  cfg_wait = 3'd0;
  logic        flush = 1'b0;
  logic [15:0] flush_addr = 16'h0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_pop = 1'b0;
  logic        q_full, q_empty;

  int checks = 0;
  int fails  = 0;
  int cyc;

  always #5 clk = ~clk;

  code_prefetch_queue u_dut (
    .clk, .rst_n, .cfg_page, .cfg_wait, .flush, .flush_addr,
    .mem_req, .mem_addr, .mem_rdata, .out_valid, .out_byte, .out_pop,
    .q_full, .q_empty
  );

  function automatic logic [7:0] code_at(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Expected cycles per byte, worked from the requirements
  function automatic int want_cycles(input logic page, input logic [2:0] ws);
    int w;
    w = (ws > 3'd4) ? 4 : int'(ws);
    if (page) return 2;
    return 4 + 2 * w;
  endfunction

  assign mem_rdata = code_at(mem_addr);

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_flush(input logic [15:0] a);
    @(negedge clk);
    flush = 1'b1;
    flush_addr = a;
    @(negedge clk);
    flush = 1'b0;
    check(!out_valid, "R7", "valid after flush", int'(out_valid), 0);
  endtask

  task automatic wait_req(input logic [15:0] a, output int t);
    t = 0;
    while (!(mem_req && mem_addr == a) && t < 200) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic measure(input logic [15:0] a, input int exp, input string req);
    int t;
    int n;
    wait_req(a, t);
    check(t < 200, req, "fetch seen", t, 0);
    check(cyc % 2 == 0, "R1", "fetch start parity", cyc % 2, 0);
    n = 0;
    while (mem_req && mem_addr == a && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, req, "fetch cycles", n, exp);
  endtask

  task automatic pop_expect(input logic [15:0] a, input string req);
    int t;
    t = 0;
    while (!out_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(out_byte == code_at(a), req, "head byte", int'(out_byte), int'(code_at(a)));
    out_pop = 1'b1;
    @(negedge clk);
    out_pop = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(q_empty && !q_full && !out_valid, "R4", "flags in reset",
          {q_full, q_empty, out_valid}, 3'b010);
    check(!mem_req, "R1", "no fetch in reset", int'(mem_req), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_lengths;
    cfg_page = 1'b1;
    do_flush(16'h0100);
    measure(16'h0100, want_cycles(1'b1, 3'd0), "R2");
    cfg_page = 1'b0;
    cfg_wait = 3'd0;
    do_flush(16'h0200);
    measure(16'h0200, want_cycles(1'b0, 3'd0), "R3");
    measure(16'h0201, want_cycles(1'b0, 3'd0), "R3");
    cfg_wait = 3'd2;
    do_flush(16'h0300);
    measure(16'h0300, want_cycles(1'b0, 3'd2), "R3");
    cfg_wait = 3'd4;
    do_flush(16'h0400);
    measure(16'h0400, want_cycles(1'b0, 3'd4), "R3");
    cfg_wait = 3'd6;
    do_flush(16'h0500);
    measure(16'h0500, want_cycles(1'b0, 3'd6), "R3");
  endtask

  task automatic t_fill_full;
    cfg_page = 1'b1;
    do_flush(16'h1230);
    repeat (20) @(negedge clk);
    check(q_full && out_valid, "R4", "full after four bytes", int'(q_full), 1);
    repeat (6) begin
      check(!mem_req, "R4", "fetch paused while full", int'(mem_req), 0);
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) pop_expect(16'h1230 + 16'(i), "R5");
  endtask

  task automatic t_wrap;
    cfg_page = 1'b1;
    do_flush(16'hFFFE);
    pop_expect(16'hFFFE, "R6");
    pop_expect(16'hFFFF, "R6");
    pop_expect(16'h0000, "R6");
    pop_expect(16'h0001, "R6");
  endtask

  task automatic t_stream;
    cfg_page = 1'b1;
    do_flush(16'h2000);
    for (int i = 0; i < 16; i++) pop_expect(16'h2000 + 16'(i), "R9");
    repeat (14) @(negedge clk);
    check(q_full, "R9", "refills after stream", int'(q_full), 1);
    for (int i = 16; i < 20; i++) pop_expect(16'h2000 + 16'(i), "R9");
  endtask

  task automatic t_flush_abandon;
    int t;
    cfg_page = 1'b0;
    cfg_wait = 3'd4;
    do_flush(16'h5000);
    wait_req(16'h5000, t);
    repeat (4) @(negedge clk);
    do_flush(16'h6000);
    wait_req(16'h6000, t);
    check(t <= 1, "R7", "restart delay", t, 1);
    pop_expect(16'h6000, "R7");
    pop_expect(16'h6001, "R7");
  endtask

  task automatic t_cfg_mid;
    int t;
    int n;
    cfg_page = 1'b0;
    cfg_wait = 3'd4;
    do_flush(16'h4000);
    wait_req(16'h4000, t);
    n = 0;
    while (mem_req && mem_addr == 16'h4000 && n < 100) begin
      n++;
      if (n == 2) cfg_page = 1'b1;
      @(negedge clk);
    end
    check(n == 12, "R8", "mid-fetch config change", n, 12);
    measure(16'h4001, 2, "R8");
  endtask

  task automatic t_pop_empty;
    cfg_page = 1'b0;
    cfg_wait = 3'd2;
    do_flush(16'h7010);
    out_pop = 1'b1;
    repeat (3) @(negedge clk);
    out_pop = 1'b0;
    check(q_empty && !out_valid, "R9", "pop on empty", int'(q_empty), 1);
    pop_expect(16'h7010, "R9");
    pop_expect(16'h7011, "R9");
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_fill_full();
    t_wrap();
    t_stream();
    t_flush_abandon();
    t_cfg_mid();
    t_pop_empty();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule